// File: doc/BRIEF.md
# Randomized Switched-Capacitor Phase Controller

This block sequences an array of switched capacitors that sit between the supply and a crypto core. The core never draws current straight from the supply. Each capacitor runs a repeating life cycle:

1. It is discharged to a fixed level so that no data-dependent charge is left on it.
2. It is charged from the supply.
3. It waits, charged.
4. It feeds the core for one supply slot.

Every change of phase is separated from the next by switch-off (idle) cycles, so no switch pair is ever closed at the same time.

The capacitor that feeds the core in each slot is not picked in a fixed rotation. A two-stage linear feedback shift register draws a starting index, and the first charged capacitor at or after that index wins the slot. The second register decides how far the first one advances at each draw. The transfer from core current to supply current therefore changes over time and repeats only after a long period. The controller produces one discharge, one charge and one supply enable per capacitor. The analog switches are outside this block. A single input lets slots be handed out or held back.

Top module: `scap_phase_ctrl`

## Requirements
- R1: While reset is asserted, every capacitor has its discharge enable high and its charge and supply enables low.
- R2: Each capacitor follows this cycle:
  - discharge for exactly RST_CYC cycles (3 by default);
  - exactly one idle cycle;
  - charge for exactly CHG_CYC cycles (4);
  - at least one idle cycle;
  - supply for exactly SUP_CYC cycles (4);
  - exactly one idle cycle;
  - discharge again.

  Leaving reset, every capacitor begins in discharge.
- R3: No capacitor ever has more than one of its three enables high in the same cycle.
- R4: At most one capacitor feeds the core in any cycle. When the core is handed from one capacitor to another, there is at least one cycle in which no capacitor feeds it.
- R5: A capacitor starts to supply only if it has finished a full charge phase since its last supply or since reset.
- R6: Slot selection works as follows:
  - The first register is 16 bits with seed 0xACE1. The second is 8 bits with seed 0x5B.
  - Each steps as s <= {s[W-2:0], parity(s & TAPS)}, with TAPS 0xB400 for the first register and 0xB8 for the second. A zero seed is replaced by 1.
  - At every grant, the second register steps once. The first register then steps twice if the new second-register bit 0 is 1, and once otherwise.
  - The starting index is the new first-register value modulo N_CAP (4).
  - The winner is the first charged, waiting capacitor found by scanning upward from the starting index, wrapping around.
- R7: A slot is granted in the first cycle in which the previous slot has ended (or, after reset, from the first cycle on), `run_i` is high and some capacitor is charged and waiting. The winner's supply enable rises in the next cycle. A slot that ends is therefore followed by exactly one cycle without a supplier whenever a capacitor is waiting.
- R8: While `run_i` is low, no new supply slot starts and the registers do not advance. A slot already under way runs to its end. A single cycle of `run_i` high, with a charged capacitor waiting, grants exactly one slot.
- R9: The sequence of supplying capacitors is not periodic with period N_CAP, and every capacitor supplies at least once over a long run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Allows new supply slots to be granted |
| dis_en_o | output | N_CAP | Per-capacitor discharge switch enable |
| chg_en_o | output | N_CAP | Per-capacitor charge switch enable |
| sup_en_o | output | N_CAP | Per-capacitor core-supply switch enable |

## Verification
The only free input is `run_i`. The properties assume nothing about it, except that a supply slot may start only one cycle after `run_i` was seen high. The stimulus therefore holds `run_i` high for long stretches, drops it for windows long enough for every capacitor to become charged, and then pulses it for a single cycle. These windows exercise the wide-open selection case, where all four capacitors are waiting, and the single-grant case. All inputs change one nanosecond after a rising edge, and outputs are sampled on the falling edge. The monitor can therefore tell which capacitors were waiting in the cycle of each grant.

// File: rtl/scap_pkg.sv
package scap_pkg;

    typedef enum logic [2:0] {
        CELL_DIS      = 3'd0,
        CELL_GAP_PRE  = 3'd1,
        CELL_CHG      = 3'd2,
        CELL_RDY      = 3'd3,
        CELL_SUP      = 3'd4,
        CELL_GAP_POST = 3'd5
    } cell_state_e;

    typedef enum logic {
        SCH_PICK = 1'b0,
        SCH_HOLD = 1'b1
    } sched_state_e;

endpackage

// File: rtl/scap_cell_fsm.sv
module scap_cell_fsm
    import scap_pkg::*;
#(
    parameter int unsigned RST_CYC = 3,
    parameter int unsigned CHG_CYC = 4,
    parameter int unsigned SUP_CYC = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic grant_i,
    output logic dis_en_o,
    output logic chg_en_o,
    output logic sup_en_o,
    output logic ready_o
);

    localparam int unsigned MAX_AB  = (RST_CYC > CHG_CYC) ? RST_CYC : CHG_CYC;
    localparam int unsigned MAX_CYC = (MAX_AB > SUP_CYC) ? MAX_AB : SUP_CYC;
    localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] CHG_LOAD = CNT_W'(CHG_CYC - 1);
    localparam logic [CNT_W-1:0] SUP_LOAD = CNT_W'(SUP_CYC - 1);

    typedef struct packed {
        cell_state_e      st;
        logic [CNT_W-1:0] cnt;
    } cell_reg_t;

    cell_reg_t cell_d, cell_q;

    // Next-state: each timed phase counts down its load value, idle gaps last one cycle.
    always_comb begin
        cell_d = cell_q;
        unique case (cell_q.st)
            CELL_DIS: begin
                if (cell_q.cnt == '0) cell_d.st  = CELL_GAP_PRE;
                else                  cell_d.cnt = cell_q.cnt - 1'b1;
            end
            CELL_GAP_PRE: begin
                cell_d.st  = CELL_CHG;
                cell_d.cnt = CHG_LOAD;
            end
            CELL_CHG: begin
                if (cell_q.cnt == '0) cell_d.st  = CELL_RDY;
                else                  cell_d.cnt = cell_q.cnt - 1'b1;
            end
            CELL_RDY: begin
                if (grant_i) begin
                    cell_d.st  = CELL_SUP;
                    cell_d.cnt = SUP_LOAD;
                end
            end
            CELL_SUP: begin
                if (cell_q.cnt == '0) cell_d.st  = CELL_GAP_POST;
                else                  cell_d.cnt = cell_q.cnt - 1'b1;
            end
            CELL_GAP_POST: begin
                cell_d.st  = CELL_DIS;
                cell_d.cnt = RST_LOAD;
            end
            default: begin
                cell_d.st  = CELL_DIS;
                cell_d.cnt = RST_LOAD;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cell_q.st  <= CELL_DIS;
            cell_q.cnt <= RST_LOAD;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign dis_en_o = (cell_q.st == CELL_DIS);
    assign chg_en_o = (cell_q.st == CELL_CHG);
    assign sup_en_o = (cell_q.st == CELL_SUP);
    assign ready_o  = (cell_q.st == CELL_RDY);

endmodule

// File: rtl/scap_slot_sched.sv
module scap_slot_sched
    import scap_pkg::*;
#(
    parameter int unsigned        N_CAP   = 4,
    parameter int unsigned        SUP_CYC = 4,
    parameter int unsigned        A_W     = 16,
    parameter logic [A_W-1:0]     A_TAPS  = 16'hB400,
    parameter logic [A_W-1:0]     A_SEED  = 16'hACE1,
    parameter int unsigned        B_W     = 8,
    parameter logic [B_W-1:0]     B_TAPS  = 8'hB8,
    parameter logic [B_W-1:0]     B_SEED  = 8'h5B
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [N_CAP-1:0] ready_i,
    output logic [N_CAP-1:0] grant_o
);

    localparam int unsigned IDX_W = (N_CAP > 1) ? $clog2(N_CAP) : 1;
    localparam int unsigned CNT_W = (SUP_CYC > 1) ? $clog2(SUP_CYC) : 1;
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(SUP_CYC - 1);
    localparam logic [A_W-1:0] A_INIT = (A_SEED == '0) ? A_W'(1) : A_SEED;
    localparam logic [B_W-1:0] B_INIT = (B_SEED == '0) ? B_W'(1) : B_SEED;

    typedef struct packed {
        sched_state_e     st;
        logic [A_W-1:0]   a;
        logic [B_W-1:0]   b;
        logic [CNT_W-1:0] cnt;
    } sched_reg_t;

    sched_reg_t sch_d, sch_q;

    logic [B_W-1:0]   b_nx;
    logic [A_W-1:0]   a_once;
    logic [A_W-1:0]   a_nx;
    logic             fire;
    logic             found;
    logic [IDX_W-1:0] sel;
    logic [IDX_W-1:0] probe;
    int unsigned      cand;

    function automatic logic [A_W-1:0] adv_a(input logic [A_W-1:0] s);
        return {s[A_W-2:0], ^(s & A_TAPS)};
    endfunction

    function automatic logic [B_W-1:0] adv_b(input logic [B_W-1:0] s);
        return {s[B_W-2:0], ^(s & B_TAPS)};
    endfunction

    always_comb begin
        sch_d   = sch_q;
        grant_o = '0;
        // Second stage decides whether the first stage takes one or two steps.
        b_nx    = adv_b(sch_q.b);
        a_once  = adv_a(sch_q.a);
        a_nx    = b_nx[0] ? adv_a(a_once) : a_once;
        cand    = 32'(a_nx) % N_CAP;
        found   = 1'b0;
        sel     = '0;
        probe   = '0;
        for (int unsigned k = 0; k < N_CAP; k++) begin
            probe = IDX_W'((cand + k) % N_CAP);
            if (!found && ready_i[probe]) begin
                found = 1'b1;
                sel   = probe;
            end
        end
        fire = (sch_q.st == SCH_PICK) && run_i && found;

        unique case (sch_q.st)
            SCH_PICK: begin
                if (fire) begin
                    grant_o[sel] = 1'b1;
                    sch_d.a      = a_nx;
                    sch_d.b      = b_nx;
                    sch_d.st     = SCH_HOLD;
                    sch_d.cnt    = HOLD_LOAD;
                end
            end
            SCH_HOLD: begin
                if (sch_q.cnt == '0) sch_d.st  = SCH_PICK;
                else                 sch_d.cnt = sch_q.cnt - 1'b1;
            end
            default: sch_d.st = SCH_PICK;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sch_q.st  <= SCH_PICK;
            sch_q.a   <= A_INIT;
            sch_q.b   <= B_INIT;
            sch_q.cnt <= '0;
        end else begin
            sch_q <= sch_d;
        end
    end

endmodule

// File: rtl/scap_phase_ctrl.sv
module scap_phase_ctrl #(
    parameter int unsigned N_CAP   = 4,
    parameter int unsigned RST_CYC = 3,
    parameter int unsigned CHG_CYC = 4,
    parameter int unsigned SUP_CYC = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    output logic [N_CAP-1:0] dis_en_o,
    output logic [N_CAP-1:0] chg_en_o,
    output logic [N_CAP-1:0] sup_en_o
);

    logic [N_CAP-1:0] ready;
    logic [N_CAP-1:0] grant;

    for (genvar gi = 0; gi < N_CAP; gi++) begin : g_cell
        scap_cell_fsm #(
            .RST_CYC (RST_CYC),
            .CHG_CYC (CHG_CYC),
            .SUP_CYC (SUP_CYC)
        ) u_cell (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .grant_i  (grant[gi]),
            .dis_en_o (dis_en_o[gi]),
            .chg_en_o (chg_en_o[gi]),
            .sup_en_o (sup_en_o[gi]),
            .ready_o  (ready[gi])
        );
    end

    scap_slot_sched #(
        .N_CAP   (N_CAP),
        .SUP_CYC (SUP_CYC)
    ) u_sched (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run_i),
        .ready_i (ready),
        .grant_o (grant)
    );

endmodule

// File: rtl/scap_phase_ctrl_chk.sv
module scap_phase_ctrl_chk #(
    parameter int unsigned N_CAP = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             run_i,
    input logic [N_CAP-1:0] dis_en_o,
    input logic [N_CAP-1:0] chg_en_o,
    input logic [N_CAP-1:0] sup_en_o
);

    logic [N_CAP-1:0] charged_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            charged_q <= '0;
        end else begin
            for (int i = 0; i < N_CAP; i++) begin
                if (chg_en_o[i])      charged_q[i] <= 1'b1;
                else if (sup_en_o[i]) charged_q[i] <= 1'b0;
            end
        end
    end

    for (genvar gi = 0; gi < N_CAP; gi++) begin : g_cap
        assert_one_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $onehot0({dis_en_o[gi], chg_en_o[gi], sup_en_o[gi]}));

        assert_idle_before_supply_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(sup_en_o[gi]) |-> $past(!chg_en_o[gi] && !dis_en_o[gi]));

        assert_idle_after_supply_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(sup_en_o[gi]) |-> (!dis_en_o[gi] && !chg_en_o[gi]));

        assert_discharge_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(sup_en_o[gi]) |=> dis_en_o[gi]);

        assert_charged_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(sup_en_o[gi]) |-> charged_q[gi]);
    end

    assert_single_supplier_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(sup_en_o));

    assert_handover_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((sup_en_o != '0) && ($past(sup_en_o) != '0)) |-> (sup_en_o == $past(sup_en_o)));

    assert_run_gates_slot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((sup_en_o & ~$past(sup_en_o)) != '0) |-> $past(run_i));

endmodule

bind scap_phase_ctrl scap_phase_ctrl_chk #(.N_CAP(N_CAP)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .dis_en_o (dis_en_o),
    .chg_en_o (chg_en_o),
    .sup_en_o (sup_en_o)
);

// File: tb/tb_scap_phase_ctrl.sv
module tb_scap_phase_ctrl;

    localparam int N   = 4;
    localparam int RST = 3;
    localparam int CHG = 4;
    localparam int SUP = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run = 1'b0;
    logic [N-1:0] dis_en;
    logic [N-1:0] chg_en;
    logic [N-1:0] sup_en;

    always #2 clk = ~clk;

    scap_phase_ctrl #(.N_CAP(N), .RST_CYC(RST), .CHG_CYC(CHG), .SUP_CYC(SUP)) dut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .run_i    (run),
        .dis_en_o (dis_en),
        .chg_en_o (chg_en),
        .sup_en_o (sup_en)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cand_q[$];
    int seq[$];
    int n_starts = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    int cur[N];
    int len[N];
    int lastnz[N];
    bit ready[N];
    bit prev_ready[N];
    logic [N-1:0] prev_sup = '0;
    bit pick_open = 1'b1;
    bit expect_start = 1'b0;
    bit prev_run = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver side of the scoreboard: starting indices from the two-register rule (R6).
    task automatic push_candidates(input int n);
        logic [15:0] a = 16'hACE1;
        logic [7:0]  b = 8'h5B;
        for (int k = 0; k < n; k++) begin
            b = {b[6:0], b[7] ^ b[5] ^ b[4] ^ b[3]};
            a = {a[14:0], a[15] ^ a[13] ^ a[12] ^ a[10]};
            if (b[0]) a = {a[14:0], a[15] ^ a[13] ^ a[12] ^ a[10]};
            cand_q.push_back(int'(a) % N);
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            cur[i] = 1; len[i] = 0; lastnz[i] = 0; ready[i] = 0; prev_ready[i] = 0;
        end
    end

    // Monitor: phase tracking, grant timing, scoreboard pop and compare.
    always @(negedge clk) begin
        if (mon_en && !done) begin : mon
            logic [N-1:0] rise;
            int ph, on, c, exp_idx;
            bit any_ready;
            rise = sup_en & ~prev_sup;

            if (expect_start) check(rise != '0, "R7 slot start", int'(rise), 1);
            else if (rise != '0) check(1'b0, prev_run ? "R7 early start" : "R8 start while held", int'(rise), 0);

            for (int i = 0; i < N; i++) begin
                if (rise[i]) begin
                    n_starts++;
                    seq.push_back(i);
                    check(prev_ready[i], "R5 supply without charge", i, -1);
                    if (cand_q.size() == 0) begin
                        check(1'b0, "R6 queue empty", 0, 1);
                    end else begin
                        c = cand_q.pop_front();
                        exp_idx = -1;
                        for (int k = 0; k < N; k++)
                            if (exp_idx < 0 && prev_ready[(c + k) % N]) exp_idx = (c + k) % N;
                        check(i == exp_idx, "R6 selected capacitor", i, exp_idx);
                    end
                end
            end
            if (rise != '0) pick_open = 1'b0;
            if (prev_sup != '0 && sup_en == '0) pick_open = 1'b1;

            for (int i = 0; i < N; i++) begin
                on = int'(dis_en[i]) + int'(chg_en[i]) + int'(sup_en[i]);
                check(on <= 1, "R3 enables per capacitor", on, 1);
                ph = sup_en[i] ? 3 : (chg_en[i] ? 2 : (dis_en[i] ? 1 : 0));
                if (cur[i] == 2 && ph == 0) ready[i] = 1'b1;
                if (ph == 3) ready[i] = 1'b0;
                if (ph != cur[i]) begin
                    if (cur[i] != 0) begin
                        check(len[i] == (cur[i] == 1 ? RST : (cur[i] == 2 ? CHG : SUP)),
                              "R2 phase length", len[i], (cur[i] == 1 ? RST : (cur[i] == 2 ? CHG : SUP)));
                        if (ph != 0) check(1'b0, "R2 missing idle cycle", ph, 0);
                        lastnz[i] = cur[i];
                    end else begin
                        if (lastnz[i] == 3)      check(ph == 1 && len[i] == 1, "R2 after supply", ph * 100 + len[i], 101);
                        else if (lastnz[i] == 1) check(ph == 2 && len[i] == 1, "R2 after discharge", ph * 100 + len[i], 201);
                        else if (lastnz[i] == 2) check(ph == 3 && len[i] >= 1, "R2 after charge", ph * 100 + len[i], 301);
                    end
                    cur[i] = ph;
                    len[i] = 1;
                end else begin
                    len[i]++;
                end
            end

            any_ready = 1'b0;
            for (int i = 0; i < N; i++) any_ready |= ready[i];
            expect_start = pick_open && run && any_ready;
            prev_run = run;
            for (int i = 0; i < N; i++) prev_ready[i] = ready[i];
            prev_sup = sup_en;
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int s0;
        bit periodic;
        bit used[N];
        push_candidates(300);

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(dis_en == '1 && chg_en == '0 && sup_en == '0, "R1 reset state",
              int'({dis_en, chg_en, sup_en}), int'({{N{1'b1}}, {2*N{1'b0}}}));
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        run = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);
        check(dis_en == '1 && sup_en == '0, "R1 first cycle after reset", int'(dis_en), (1 << N) - 1);

        repeat (160) @(posedge clk);
        #1 run = 1'b0;
        repeat (2) @(posedge clk);
        s0 = n_starts;
        repeat (48) @(posedge clk);
        check(n_starts == s0, "R8 held window", n_starts - s0, 0);
        #1 run = 1'b1;
        repeat (160) @(posedge clk);
        #1 run = 1'b0;
        repeat (40) @(posedge clk);
        s0 = n_starts;
        #1 run = 1'b1;
        @(posedge clk);
        #1 run = 1'b0;
        repeat (30) @(posedge clk);
        check(n_starts == s0 + 1, "R8 single-cycle run pulse", n_starts - s0, 1);

        periodic = 1'b1;
        for (int k = N; k < seq.size(); k++) if (seq[k] != seq[k-N]) periodic = 1'b0;
        check(seq.size() >= 2 * N && !periodic, "R9 order not a fixed rotation", int'(periodic), 0);
        for (int i = 0; i < N; i++) used[i] = 1'b0;
        foreach (seq[k]) used[seq[k]] = 1'b1;
        for (int i = 0; i < N; i++) check(used[i], "R9 every capacitor supplies", int'(used[i]), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule